// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block holds a microcontroller in reset when its supply droops. An external undervoltage comparator drives `uv_i` high while the supply is below the trip level. A 2-bit configuration field chooses when supervision is armed. A short excursion is filtered by a cycle counter. A sustained one asserts the system reset, and the reset is held while the supply stays low. When the supply recovers, the reset can optionally be stretched by a power-up delay counter.

The block also models the small status register that goes with this function. It holds a software arm bit, which only has meaning in the software-gated mode. It also holds two cause flags, one for power-on and one for brown-out. Firmware sets both flags to 1. A later read that shows the power-on flag still 1 and the brown-out flag 0 identifies a brown-out. There is no streaming data path: every pin is a plain level or a single-cycle strobe, and there is no back-pressure.

Top module: `bor_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `sys_rst_o`, `sw_en_o`, `por_flag_o` and `bor_flag_o` are all 0.
- R2: Mode encoding in `cfg_mode_i`: 2'b00 is off, 2'b01 is software-gated, 2'b10 is hardware-armed except in sleep, and 2'b11 is always armed. In mode 2'b00, `uv_i` never causes `sys_rst_o` to rise.
- R3: When supervision is armed, `sys_rst_o` rises in the cycle after `uv_i` has been sampled high on FILT_CYC consecutive clock edges. A shorter high run, followed by a low sample, leaves `sys_rst_o` low and restarts the count.
- R4: Once `sys_rst_o` is high and supervision stays armed, it stays high for as long as `uv_i` is sampled high.
- R5: With `pwrt_en_i` low, `sys_rst_o` falls in the cycle after the first low sample of `uv_i`.
- R6: With `pwrt_en_i` high, the first low sample of `uv_i` starts a delay. `sys_rst_o` then stays high for exactly PWRT_CYC further clock edges. `pwrt_en_i` has no effect on when the reset is triggered.
- R7: If `uv_i` is sampled high during the delay, the block returns at once to the held state. After the next low sample, the full PWRT_CYC delay runs again.
- R8: The software arm bit is written by `sw_en_wr_i` with the value on `sw_en_wdata_i`. The write only takes effect in mode 2'b01. `sw_en_o` reads 0 in any other mode. In mode 2'b01, supervision is armed only while the bit is 1.
- R9: In mode 2'b10, supervision is disarmed while `sleep_i` is high, and is armed again as soon as `sleep_i` is low.
- R10: `bor_flag_o` is cleared in the same cycle that `sys_rst_o` rises. `bor_flag_set_i` and `por_flag_set_i` each set their flag to 1. `rst_n` clears both flags.
- R11: If supervision is disarmed while reset is held with `uv_i` high, `sys_rst_o` falls on the next edge. If it is disarmed during the power-up delay, the delay still runs to its end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| uv_i | input | 1 | Undervoltage comparator output, high means the supply is low |
| cfg_mode_i | input | 2 | Supervision mode selector |
| sleep_i | input | 1 | Core is in sleep |
| pwrt_en_i | input | 1 | Enable the power-up delay |
| sw_en_wr_i | input | 1 | Write strobe for the software arm bit |
| sw_en_wdata_i | input | 1 | Value written to the software arm bit |
| por_flag_set_i | input | 1 | Strobe that sets the power-on flag |
| bor_flag_set_i | input | 1 | Strobe that sets the brown-out flag |
| sys_rst_o | output | 1 | System reset request, active high |
| sw_en_o | output | 1 | Readback of the software arm bit |
| por_flag_o | output | 1 | Power-on flag, 0 after power-on reset |
| bor_flag_o | output | 1 | Brown-out flag, 0 after a brown-out reset |

## Verification
The hardest situation to reach is a re-dip during the power-up delay. The supply has to fail long enough to trip the reset, recover for fewer than PWRT_CYC cycles, and then fail again, so the restart of the delay is only visible in the exact cycle `sys_rst_o` finally falls. The bench scripts that three-phase waveform directly and computes the fall cycle from the second recovery. It also sweeps every mode, sleep, arm bit and delay-enable combination against dip lengths on both sides of the filter interval. A further case disarms the block in the middle of the held state, by writing the arm bit, to reach the early release.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SW    = 2'b01,
    MODE_NOSLP = 2'b10,
    MODE_ON    = 2'b11
  } bor_mode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_FILTER = 2'b01,
    ST_HOLD   = 2'b10,
    ST_DELAY  = 2'b11
  } bor_state_e;

endpackage

// File: rtl/bor_cycle_timer.sv
module bor_cycle_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // Counts consecutive step cycles; any idle cycle returns it to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
    else           cnt_q <= '0;
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/bor_enable_ctl.sv
module bor_enable_ctl
  import bor_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode_i,
  input  logic       sleep_i,
  input  logic       sw_en_wr_i,
  input  logic       sw_en_wdata_i,
  output logic       sw_en_o,
  output logic       armed_o
);
  bor_mode_e mode;
  logic      sw_en_q;

  assign mode = bor_mode_e'(cfg_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             sw_en_q <= 1'b0;
    else if (sw_en_wr_i && mode == MODE_SW) sw_en_q <= sw_en_wdata_i;
  end

  always_comb begin
    unique case (mode)
      MODE_OFF:   armed_o = 1'b0;
      MODE_SW:    armed_o = sw_en_q;
      MODE_NOSLP: armed_o = ~sleep_i;
      MODE_ON:    armed_o = 1'b1;
      default:    armed_o = 1'b0;
    endcase
  end

  assign sw_en_o = (mode == MODE_SW) && sw_en_q;
endmodule

// File: rtl/bor_status_flags.sv
module bor_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic bor_evt_i,
  input  logic por_set_i,
  input  logic bor_set_i,
  output logic por_flag_o,
  output logic bor_flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_flag_o <= 1'b0;
      bor_flag_o <= 1'b0;
    end else begin
      if (por_set_i) por_flag_o <= 1'b1;
      // A new brown-out event wins over a simultaneous software set.
      if (bor_evt_i)      bor_flag_o <= 1'b0;
      else if (bor_set_i) bor_flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/bor_seq_ctrl.sv
module bor_seq_ctrl
  import bor_pkg::*;
#(
  parameter int FILT_CYC = 4,
  parameter int PWRT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       sleep_i,
  input  logic       pwrt_en_i,
  input  logic       sw_en_wr_i,
  input  logic       sw_en_wdata_i,
  input  logic       por_flag_set_i,
  input  logic       bor_flag_set_i,
  output logic       sys_rst_o,
  output logic       sw_en_o,
  output logic       por_flag_o,
  output logic       bor_flag_o
);
  bor_state_e state_q, state_d;
  logic       armed, trip, flt_step, flt_done, pw_step, pw_done, bor_evt;

  bor_enable_ctl u_en (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode_i    (cfg_mode_i),
    .sleep_i       (sleep_i),
    .sw_en_wr_i    (sw_en_wr_i),
    .sw_en_wdata_i (sw_en_wdata_i),
    .sw_en_o       (sw_en_o),
    .armed_o       (armed)
  );

  assign trip = armed && uv_i;

  // Filter counter: consecutive armed-low-supply samples outside reset.
  assign flt_step = (state_q == ST_RUN || state_q == ST_FILTER) && trip && !flt_done;

  bor_cycle_timer #(.LIMIT(FILT_CYC)) u_flt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (flt_step),
    .done  (flt_done)
  );

  // Power-up delay counter: runs only in the delay state, cleared by a re-dip.
  assign pw_step = (state_q == ST_DELAY) && !trip && !pw_done;

  bor_cycle_timer #(.LIMIT(PWRT_CYC)) u_pwrt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (pw_step),
    .done  (pw_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN, ST_FILTER: begin
        if (trip) state_d = flt_done ? ST_HOLD : ST_FILTER;
        else      state_d = ST_RUN;
      end
      ST_HOLD: begin
        if (!armed)     state_d = ST_RUN;
        else if (!uv_i) state_d = pwrt_en_i ? ST_DELAY : ST_RUN;
      end
      ST_DELAY: begin
        if (trip)         state_d = ST_HOLD;
        else if (pw_done) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign sys_rst_o = (state_q == ST_HOLD) || (state_q == ST_DELAY);
  assign bor_evt   = (state_d == ST_HOLD) && (state_q != ST_HOLD);

  bor_status_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .bor_evt_i  (bor_evt),
    .por_set_i  (por_flag_set_i),
    .bor_set_i  (bor_flag_set_i),
    .por_flag_o (por_flag_o),
    .bor_flag_o (bor_flag_o)
  );
endmodule

// File: rtl/bor_seq_ctrl_chk.sv
module bor_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_i,
  input logic [1:0] cfg_mode_i,
  input logic       sleep_i,
  input logic       sys_rst_o,
  input logic       bor_flag_o
);
  // R2
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode_i == 2'b00 && !sys_rst_o) |=> !sys_rst_o);

  // R3
  no_trip_without_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_i && !sys_rst_o) |=> !sys_rst_o);

  // R4
  hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o && uv_i && cfg_mode_i == 2'b11) |=> sys_rst_o);

  // R5
  release_needs_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o && cfg_mode_i == 2'b11 && uv_i) |=> !$fell(sys_rst_o));

  // R9
  sleep_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode_i == 2'b10 && sleep_i && !sys_rst_o) |=> !sys_rst_o);

  // R10
  flag_cleared_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> !bor_flag_o);
endmodule

bind bor_seq_ctrl bor_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .uv_i       (uv_i),
  .cfg_mode_i (cfg_mode_i),
  .sleep_i    (sleep_i),
  .sys_rst_o  (sys_rst_o),
  .bor_flag_o (bor_flag_o)
);

// File: tb/tb_bor_seq_ctrl.sv
module tb_bor_seq_ctrl;
  localparam int F = 3;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_i = 1'b0, sleep_i = 1'b0, pwrt_en_i = 1'b0;
  logic [1:0] cfg_mode_i = 2'b11;
  logic sw_en_wr_i = 1'b0, sw_en_wdata_i = 1'b0;
  logic por_flag_set_i = 1'b0, bor_flag_set_i = 1'b0;
  logic sys_rst_o, sw_en_o, por_flag_o, bor_flag_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bor_seq_ctrl #(.FILT_CYC(F), .PWRT_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .uv_i(uv_i), .cfg_mode_i(cfg_mode_i),
    .sleep_i(sleep_i), .pwrt_en_i(pwrt_en_i), .sw_en_wr_i(sw_en_wr_i),
    .sw_en_wdata_i(sw_en_wdata_i), .por_flag_set_i(por_flag_set_i),
    .bor_flag_set_i(bor_flag_set_i), .sys_rst_o(sys_rst_o), .sw_en_o(sw_en_o),
    .por_flag_o(por_flag_o), .bor_flag_o(bor_flag_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_sw(input logic v);
    sw_en_wr_i = 1'b1; sw_en_wdata_i = v; tick(); sw_en_wr_i = 1'b0;
  endtask

  task automatic settle();
    uv_i = 1'b0;
    for (int i = 0; i < P + 4; i++) tick();
  endtask

  // One dip of len high samples; the reset window is computed from R3/R5/R6.
  task automatic dip(input logic [1:0] m, input logic slp, input logic sw,
                     input logic pw, input int len);
    logic arm, tripped;
    int   rel;
    cfg_mode_i = 2'b01; write_sw(sw);
    cfg_mode_i = m; sleep_i = slp; pwrt_en_i = pw;
    bor_flag_set_i = 1'b1; tick(); bor_flag_set_i = 1'b0;
    check("R8", sw_en_o, (m == 2'b01) && sw);
    arm = (m == 2'b11) || (m == 2'b10 && !slp) || (m == 2'b01 && sw);
    tripped = arm && (len >= F);
    rel = len + 1 + (pw ? P : 0);
    uv_i = 1'b1;
    for (int k = 1; k <= len + P + 3; k++) begin
      tick();
      if (m == 2'b00)      check("R2", sys_rst_o, 1'b0);
      else if (!tripped)   check("R3", sys_rst_o, 1'b0);
      else if (k < F)      check("R3", sys_rst_o, 1'b0);
      else if (k <= len)   check("R4", sys_rst_o, 1'b1);
      else if (pw)         check("R6", sys_rst_o, k < rel);
      else                 check("R5", sys_rst_o, k < rel);
      if (k == len) uv_i = 1'b0;
    end
    check("R10", bor_flag_o, !tripped);
    settle();
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    check("R1", sys_rst_o, 1'b0); check("R1", sw_en_o, 1'b0);
    check("R1", por_flag_o, 1'b0); check("R1", bor_flag_o, 1'b0);
    rst_n = 1'b1; tick();
    check("R1", por_flag_o, 1'b0); check("R1", bor_flag_o, 1'b0);
    por_flag_set_i = 1'b1; tick(); por_flag_set_i = 1'b0;
    check("R10", por_flag_o, 1'b1);

    // Sweep all arming combinations against dip lengths around F.
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          for (int p = 0; p < 2; p++)
            for (int l = 1; l <= F + 3; l++)
              dip(2'(m), s[0], w[0], p[0], l);

    // R8: a write outside mode 01 is ignored.
    cfg_mode_i = 2'b01; write_sw(1'b0);
    cfg_mode_i = 2'b11; write_sw(1'b1);
    cfg_mode_i = 2'b01; tick();
    check("R8", sw_en_o, 1'b0);
    uv_i = 1'b1;
    for (int k = 0; k < F + 2; k++) tick();
    check("R8", sys_rst_o, 1'b0);
    settle();

    // R7: re-dip during the delay restarts the full delay.
    cfg_mode_i = 2'b11; pwrt_en_i = 1'b1; sleep_i = 1'b0;
    uv_i = 1'b1;
    for (int k = 1; k <= 13 + 2; k++) begin
      tick();
      if (k == F + 1) uv_i = 1'b0;
      if (k == F + 3) uv_i = 1'b1;
      if (k == F + 4) uv_i = 1'b0;
      // last high sample at edge F+4, so delay ends after edge F+5+P
      if (k >= F) check("R7", sys_rst_o, k < F + 5 + P);
      else        check("R7", sys_rst_o, 1'b0);
    end
    settle();

    // R11: disarming while held releases on the next edge.
    cfg_mode_i = 2'b01; write_sw(1'b1);
    uv_i = 1'b1;
    for (int k = 0; k < F + 1; k++) tick();
    check("R11", sys_rst_o, 1'b1);
    write_sw(1'b0);
    tick();
    check("R11", sys_rst_o, 1'b0);
    settle();

    // R11: disarming during the delay lets it run to completion.
    cfg_mode_i = 2'b11; pwrt_en_i = 1'b1;
    uv_i = 1'b1;
    for (int k = 1; k <= F + P + 3; k++) begin
      tick();
      if (k == F) uv_i = 1'b0;
      if (k == F + 2) cfg_mode_i = 2'b00;
      if (k >= F) check("R11", sys_rst_o, k < F + 1 + P);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule